// File: doc/BRIEF.md
# Asynchronous Static RAM Request Controller

This block sits between a clocked request port inside the chip and an external static RAM of 32K bytes that has no clock of its own. A client raises a request with a read/write flag, a 15-bit word address and a byte of write data. The controller acknowledges it only when no memory cycle is in progress. It then drives the memory's active-low chip select, output enable and write strobe, the address lines and the outgoing data byte with its drive enable. Every analog timing figure of the memory becomes a whole number of clock cycles, and each of these counts is a parameter.

A read keeps chip select and output enable low for `RD_CYC` cycles and captures the byte at the end of that window. The captured byte is returned with a one-cycle valid pulse. The read is followed by `TURN_CYC` recovery cycles with both strobes high, so the memory's outputs have turned off before the controller drives the bus again. A write holds chip select and the write strobe low together for `WR_CYC` cycles with output enable high. Both strobes rise together, and the address and data stay on the pins for `HOLD_CYC` more cycles before the drivers let go.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select, output enable and write strobe are high (1), the data drive enable is 0 and the read valid pulse is 0.
- R2: `ack` equals `req` in any cycle where no memory cycle is in progress, and is 0 otherwise. The request fields are taken on the clock edge that ends an acknowledged cycle.
- R3: An accepted read (`req_we`=0) holds chip select and output enable low and the write strobe high for exactly `RD_CYC` cycles, starting the cycle after acknowledge, with the request address on `mem_addr`.
- R4: The byte on `mem_dq_in` at the last output-enable-low cycle of a read appears on `rd_data` in the following cycle, and `rd_valid` is 1 for that single cycle.
- R5: An accepted write (`req_we`=1) holds chip select and write strobe low together for exactly `WR_CYC` cycles, starting the cycle after acknowledge. Output enable stays high, the data drive enable is 1, and the request address and data are on `mem_addr` and `mem_dq_out`.
- R6: After both strobes of a write rise, the address and data stay driven, with the drive enable at 1, for exactly `HOLD_CYC` cycles. The drive enable then returns to 0.
- R7: After a read, chip select and output enable stay high for `TURN_CYC` cycles before the next acknowledge. The drive enable is never 1 in a cycle where the memory's outputs are on (chip select and output enable low, write strobe high).
- R8: With no memory cycle in progress, all three strobes are high and the drive enable is 0. This holds between requests and while `req` is held high across back-to-back transactions.
- R9: Address bits pass to the memory unchanged across the full range, from 0x0000 to 0x7FFF. A byte written to any address reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request word address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Data from the memory pads |

## Verification
The hardest case to reach is a write arriving in the first cycle the controller can take it after a read. This is where a missing or short turnaround would let both sides drive the data bus. The stimulus holds `req` high continuously and issues a write straight after a read to the same address. It also mixes random read/write sequences with no idle gaps over a small address set, so reads often return freshly written bytes. The bench memory model flags any cycle in which the memory outputs are on while the drive enable is set.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int M1   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int M2   = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RTURN, S_WR, S_WHOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign ack        = req && (st == S_IDLE);
  assign mem_ce_n   = !(st == S_RD || st == S_WR);
  assign mem_oe_n   = !(st == S_RD);
  assign mem_we_n   = !(st == S_WR);
  assign mem_dq_oe  = (st == S_WR) || (st == S_WHOLD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_we) begin
            st  <= S_WR;
            cnt <= CW'(WR_CYC - 1);
          end else begin
            st  <= S_RD;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rd_data  <= mem_dq_in;
          rd_valid <= 1'b1;
          st       <= S_RTURN;
          cnt      <= CW'(TURN_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_RTURN: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          st  <= S_WHOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WHOLD: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          rd_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);

  // R2
  ack_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (mem_ce_n && !mem_dq_oe));

  // R4
  rdv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  rdv_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  // R5
  wr_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

  // R5
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

  // R7
  turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R7
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe);

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
  localparam int AW = 15, DW = 8;
  localparam int RD_CYC = 2, WR_CYC = 2, HOLD_CYC = 1, TURN_CYC = 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  asram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC),
               .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  int checks = 0, fails = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [14:0] a);
    return a[7:0] ^ 8'h5A ^ {1'b0, a[14:8]};
  endfunction

  // memory model
  logic [7:0] mem[int];
  logic [7:0] ref_mem[int];

  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem[int'(mem_addr)] = mem_dq_out;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : init_val(mem_addr);
      chk(!mem_dq_oe, "R7 bus contention", mem_dq_oe, 0);
    end else mem_dq_in = '0;
  end

  // expected per-cycle behaviour
  typedef struct {
    logic [4:0]    sig;   // {ce_n, oe_n, we_n, dq_oe, rd_valid}
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;
  exp_t q[$];

  task automatic step(input bit r, input bit w, input logic [14:0] a,
                      input logic [7:0] d, output bit got);
    exp_t e;
    bit busy;
    @(negedge clk);
    #1;
    busy = (q.size() != 0);
    if (busy) e = q.pop_front();
    else begin e.sig = 5'b11100; e.a = '0; e.d = '0; e.tag = "R8 idle"; end
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid} == e.sig, e.tag,
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, e.sig);
    if (busy && (!mem_ce_n || mem_dq_oe))
      chk(mem_addr == e.a, {e.tag, " addr R9"}, mem_addr, e.a);
    if (busy && mem_dq_oe)
      chk(mem_dq_out == e.d, {e.tag, " wdata"}, mem_dq_out, e.d);
    if (e.sig[0])
      chk(rd_data == e.d, "R4 rd_data", rd_data, e.d);
    req = r; req_we = w; req_addr = a; req_wdata = d;
    #1;
    chk(ack == (r && !busy), "R2 ack", ack, r && !busy);
    got = ack;
    if (ack) begin
      exp_t n;
      n.a = a;
      if (w) begin
        ref_mem[int'(a)] = d;
        n.d = d;
        for (int i = 0; i < WR_CYC; i++) begin n.sig = 5'b01010; n.tag = "R5 write"; q.push_back(n); end
        for (int i = 0; i < HOLD_CYC; i++) begin n.sig = 5'b11110; n.tag = "R6 hold"; q.push_back(n); end
      end else begin
        n.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
        for (int i = 0; i < RD_CYC; i++) begin n.sig = 5'b00100; n.tag = "R3 read"; q.push_back(n); end
        for (int i = 0; i < TURN_CYC; i++) begin
          n.sig = (i == 0) ? 5'b11101 : 5'b11100; n.tag = "R7 turn"; q.push_back(n);
        end
      end
    end
  endtask

  task automatic txn(input bit w, input logic [14:0] a, input logic [7:0] d);
    bit got;
    do step(1'b1, w, a, d, got); while (!got);
  endtask

  task automatic gap(input int n);
    bit got;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, got);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] pool[8];
    bit got;
    pool = '{15'h0000, 15'h7FFF, 15'h0001, 15'h4000, 15'h2AAA, 15'h5555, 15'h1234, 15'h7FFE};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid} == 5'b11100, "R1 reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 5'b11100);
    end
    rst_n = 1;
    step(1'b0, 1'b0, '0, '0, got);   // R1 first cycle after reset
    // R9 range ends, R5/R6 writes, R3/R4 reads
    txn(1, 15'h0000, 8'h3C);
    txn(1, 15'h7FFF, 8'hC3);
    gap(2);
    txn(0, 15'h0000, 8'h00);
    txn(0, 15'h7FFF, 8'h00);
    // R7 read immediately followed by a write to the same address
    txn(0, 15'h7FFF, 8'h00);
    txn(1, 15'h7FFF, 8'h81);
    txn(0, 15'h7FFF, 8'h00);
    // unwritten location
    txn(0, 15'h1234, 8'h00);
    gap(3);
    // R8 back-to-back random mix with req held high
    for (int k = 0; k < 400; k++) begin
      txn($urandom_range(0, 1), pool[$urandom_range(0, 7)], 8'($urandom));
      if ($urandom_range(0, 3) == 0) gap($urandom_range(1, 2));
    end
    gap(RD_CYC + WR_CYC + HOLD_CYC + TURN_CYC + 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule